// File: doc/BRIEF.md
# Byte-Oriented Accumulator Execute Unit

This block decodes and executes the byte-class instructions of an 8-bit accumulator processor that uses 16-bit instruction words. Each accepted word combines the working register (W) with one file register operand (F). The block returns the result, where that result is written, the updated status flags, a skip request and a cycle cost. The datapath is combinational. A small sequencer between words discards the instruction that follows a taken skip. It also tracks the two-word register-to-register move.

The surrounding pipeline supplies the fetched word together with `valid_i`, the current W value, the file operand that has already been read, and the current flags. It commits whatever the block reports for that word. It also performs the file-to-file transfer when `move_o` is raised.

Top module: `byte_exec_unit`

## Requirements
- R1: Word fields are: opcode in bits 15:10, destination bit d in bit 9 (0 selects W, 1 selects F), access bit in bit 8 (ignored), file address in bits 7:0. The instructions without a d bit work as follows. Clear (0110101), set (0110100), negate (0110110) and move-W-to-F (0110111) always write F. Compares and test write nothing. `wr_w_o`, `wr_f_o` and `move_o` are never active together.
- R2: Flags are packed as bit0 C, bit1 DC, bit2 Z, bit3 OV, bit4 N. The following instructions update all five flags: add (001001), add with carry (001000), F minus W (010111), F minus W with borrow (010110), W minus F with borrow (010101), increment (001010), decrement (000001) and negate. DC is the carry out of bit 3. OV is signed overflow. On subtraction C=1 means no borrow, and the borrow input is the inverse of C.
- R3: AND (000101), OR (000100), XOR (000110), complement (000111) and move F (010100) change only Z and N.
- R4: Rotate left through carry (001101) and rotate right through carry (001100) change C, Z and N. Rotate left (010001) and rotate right (010000) without carry change only Z and N.
- R5: Clear changes only Z, which it sets. Set (result FF), nibble swap (001110) and move-W-to-F leave every flag unchanged.
- R6: Compare-skip instructions compare F with W as unsigned values: equal (0110001), greater (0110010) and less (0110000). Test (0110011) skips when F is zero. None of them writes anything or changes a flag.
- R7: Increment-skip-if-zero (001111), increment-skip-if-nonzero (010010), decrement-skip-if-zero (001011) and decrement-skip-if-nonzero (010011) write the new value as selected by d. They skip on the condition tested on that new value, and they leave the flags unchanged.
- R8: `cycles_o` is 2 for a taken skip and for the first move word. It is 1 for any other accepted word and 0 when `valid_i` is low.
- R9: The accepted word after a taken skip is squashed. `squash_o` is 1, no write, skip or move is produced, and the flags pass through unchanged.
- R10: If the squashed word is a move first word (top nibble 1100), the next accepted word is also squashed. The skip therefore costs three cycles.
- R11: The move first word (top nibble 1100) carries a 12-bit source address. The next accepted word supplies the 12-bit destination address in bits 11:0. On that word `move_o` pulses with `mv_src_o`/`mv_dst_o`, and there is no register write and no flag change.
- R12: A word whose top nibble is 1111, arriving when no move is pending, is a NOP. It produces no write, no skip and no move, and the flags are unchanged.
- R13: While `valid_i` is low, all strobes are low, the flags pass through, and any pending squash or move waits for the next accepted word.
- R14: Under reset all strobes are low and the sequencer starts in normal execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 16 | Instruction word |
| wreg_i | input | 8 | Working register value |
| fopd_i | input | 8 | File register operand |
| flags_i | input | 5 | Current flags {N,OV,Z,DC,C} |
| result_o | output | 8 | Computed result |
| wr_w_o | output | 1 | Write result to W |
| wr_f_o | output | 1 | Write result to F |
| flags_o | output | 5 | Next flags |
| skip_o | output | 1 | Skip taken |
| squash_o | output | 1 | Current word executes as NOP |
| cycles_o | output | 2 | Cycle cost of current word |
| move_o | output | 1 | Register-to-register move fires |
| mv_src_o | output | 12 | Move source address |
| mv_dst_o | output | 12 | Move destination address |

## Verification
The assertions assume two things. First, the caller presents a fresh instruction word whenever `valid_i` is high. Second, the word that follows a move first word is the destination word. The stimulus always follows each 1100 word with a 1111 word, and it may insert idle cycles between them. After every taken skip in the vector walk, the bench issues a filler NOP word so that the squash it expects does not fall on a tabulated vector. `flags_i` and `wreg_i` are held at the values in each vector for the whole cycle in which that vector is checked.

// File: rtl/bexu_pkg.sv
package bexu_pkg;
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_DC = 1;
  localparam int unsigned FLG_Z  = 2;
  localparam int unsigned FLG_OV = 3;
  localparam int unsigned FLG_N  = 4;
  localparam int unsigned FLG_W  = 5;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB, OP_INC, OP_DEC,
    OP_NEG, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV, OP_CLR, OP_SET, OP_MOVW,
    OP_RLC, OP_RLN, OP_RRC, OP_RRN, OP_SWAP, OP_INCSZ, OP_INCSNZ, OP_DECSZ,
    OP_DECSNZ, OP_CPEQ, OP_CPGT, OP_CPLT, OP_TST, OP_MV1
  } op_e;

  typedef enum logic [1:0] {TGT_NONE, TGT_W, TGT_F} tgt_e;

  typedef enum logic [1:0] {SQ_RUN, SQ_DROP, SQ_DROP2, SQ_MOVE} seq_e;

  function automatic logic is_skip_op(op_e op);
    return op inside {OP_INCSZ, OP_INCSNZ, OP_DECSZ, OP_DECSNZ,
                      OP_CPEQ, OP_CPGT, OP_CPLT, OP_TST};
  endfunction
endpackage

// File: rtl/bexu_decode.sv
module bexu_decode
  import bexu_pkg::*;
#(
  parameter int unsigned INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output tgt_e               tgt_o
);
  localparam int unsigned OPC_LSB = INSTR_W - 6;
  localparam int unsigned D_BIT   = OPC_LSB - 1;

  logic [5:0] opc;
  logic       d_sel;
  logic       has_d;

  assign opc   = instr_i[INSTR_W-1:OPC_LSB];
  assign d_sel = instr_i[D_BIT];

  always_comb begin
    op_o  = OP_NONE;
    has_d = 1'b1;
    unique case (opc)
      6'b001001: op_o = OP_ADD;
      6'b001000: op_o = OP_ADDC;
      6'b010111: op_o = OP_SUBWF;
      6'b010110: op_o = OP_SUBWFB;
      6'b010101: op_o = OP_SUBFWB;
      6'b001010: op_o = OP_INC;
      6'b000001: op_o = OP_DEC;
      6'b000101: op_o = OP_AND;
      6'b000100: op_o = OP_IOR;
      6'b000110: op_o = OP_XOR;
      6'b000111: op_o = OP_COM;
      6'b010100: op_o = OP_MOV;
      6'b001101: op_o = OP_RLC;
      6'b010001: op_o = OP_RLN;
      6'b001100: op_o = OP_RRC;
      6'b010000: op_o = OP_RRN;
      6'b001110: op_o = OP_SWAP;
      6'b001111: op_o = OP_INCSZ;
      6'b010010: op_o = OP_INCSNZ;
      6'b001011: op_o = OP_DECSZ;
      6'b010011: op_o = OP_DECSNZ;
      6'b011000: begin has_d = 1'b0; op_o = d_sel ? OP_CPEQ : OP_CPLT; end
      6'b011001: begin has_d = 1'b0; op_o = d_sel ? OP_TST  : OP_CPGT; end
      6'b011010: begin has_d = 1'b0; op_o = d_sel ? OP_CLR  : OP_SET;  end
      6'b011011: begin has_d = 1'b0; op_o = d_sel ? OP_MOVW : OP_NEG;  end
      default: begin
        has_d = 1'b0;
        if (opc[5:2] == 4'b1100) op_o = OP_MV1;
      end
    endcase
  end

  always_comb begin
    tgt_o = TGT_NONE;
    if (op_o inside {OP_CLR, OP_SET, OP_NEG, OP_MOVW}) tgt_o = TGT_F;
    else if (has_d && op_o != OP_NONE
             && !(op_o inside {OP_CPEQ, OP_CPGT, OP_CPLT, OP_TST}))
      tgt_o = d_sel ? TGT_F : TGT_W;
  end
endmodule

// File: rtl/bexu_alu.sv
module bexu_alu
  import bexu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] f_i,
  input  logic [FLG_W-1:0]  flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic              cond_o
);
  localparam int unsigned NIB = DATA_W / 2;
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] opa, opb;
  logic              cin;
  logic [DATA_W:0]   sum;
  logic [NIB:0]      lsum;
  logic              ovf;
  logic              upd_zn;

  // shared adder; subtraction as a + ~b + carry
  always_comb begin
    opa = f_i;
    opb = '0;
    cin = 1'b0;
    unique case (op_i)
      OP_ADD:    begin opb = w_i; end
      OP_ADDC:   begin opb = w_i; cin = flags_i[FLG_C]; end
      OP_SUBWF:  begin opb = ~w_i; cin = 1'b1; end
      OP_SUBWFB: begin opb = ~w_i; cin = flags_i[FLG_C]; end
      OP_SUBFWB: begin opa = w_i; opb = ~f_i; cin = flags_i[FLG_C]; end
      OP_INC, OP_INCSZ, OP_INCSNZ: cin = 1'b1;
      OP_DEC, OP_DECSZ, OP_DECSNZ: opb = '1;
      OP_NEG:    begin opa = '0; opb = ~f_i; cin = 1'b1; end
      default: ;
    endcase
  end

  assign sum  = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
  assign lsum = {1'b0, opa[NIB-1:0]} + {1'b0, opb[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign ovf  = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);

  always_comb begin
    res_o   = f_i;
    flags_o = flags_i;
    cond_o  = 1'b0;
    upd_zn  = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB, OP_INC, OP_DEC, OP_NEG: begin
        res_o           = sum[DATA_W-1:0];
        flags_o[FLG_C]  = sum[DATA_W];
        flags_o[FLG_DC] = lsum[NIB];
        flags_o[FLG_OV] = ovf;
        upd_zn          = 1'b1;
      end
      OP_INCSZ, OP_DECSZ: begin
        res_o  = sum[DATA_W-1:0];
        cond_o = ~|sum[DATA_W-1:0];
      end
      OP_INCSNZ, OP_DECSNZ: begin
        res_o  = sum[DATA_W-1:0];
        cond_o = |sum[DATA_W-1:0];
      end
      OP_AND: begin res_o = w_i & f_i; upd_zn = 1'b1; end
      OP_IOR: begin res_o = w_i | f_i; upd_zn = 1'b1; end
      OP_XOR: begin res_o = w_i ^ f_i; upd_zn = 1'b1; end
      OP_COM: begin res_o = ~f_i;      upd_zn = 1'b1; end
      OP_MOV: begin res_o = f_i;       upd_zn = 1'b1; end
      OP_CLR: begin res_o = '0; flags_o[FLG_Z] = 1'b1; end
      OP_SET:  res_o = '1;
      OP_MOVW: res_o = w_i;
      OP_SWAP: res_o = {f_i[NIB-1:0], f_i[DATA_W-1:NIB]};
      OP_RLC: begin
        res_o          = {f_i[MSB-1:0], flags_i[FLG_C]};
        flags_o[FLG_C] = f_i[MSB];
        upd_zn         = 1'b1;
      end
      OP_RRC: begin
        res_o          = {flags_i[FLG_C], f_i[MSB:1]};
        flags_o[FLG_C] = f_i[0];
        upd_zn         = 1'b1;
      end
      OP_RLN: begin res_o = {f_i[MSB-1:0], f_i[MSB]}; upd_zn = 1'b1; end
      OP_RRN: begin res_o = {f_i[0], f_i[MSB:1]};     upd_zn = 1'b1; end
      OP_CPEQ: cond_o = (f_i == w_i);
      OP_CPGT: cond_o = (f_i > w_i);
      OP_CPLT: cond_o = (f_i < w_i);
      OP_TST:  cond_o = ~|f_i;
      default: ;
    endcase
    if (upd_zn) begin
      flags_o[FLG_Z] = ~|res_o;
      flags_o[FLG_N] = res_o[MSB];
    end
  end
endmodule

// File: rtl/bexu_seq.sv
module bexu_seq
  import bexu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              skip_take_i,
  input  logic              mv_first_i,
  input  logic              word_mv1_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              squash_o,
  output logic              mv_second_o,
  output logic [ADDR_W-1:0] src_o
);
  seq_e              state_q, state_d;
  logic [ADDR_W-1:0] src_q;

  always_comb begin
    state_d = state_q;
    if (valid_i) begin
      unique case (state_q)
        SQ_RUN: begin
          if (skip_take_i)     state_d = SQ_DROP;
          else if (mv_first_i) state_d = SQ_MOVE;
        end
        // a squashed two-word move drags its second word along
        SQ_DROP:  state_d = word_mv1_i ? SQ_DROP2 : SQ_RUN;
        SQ_DROP2: state_d = SQ_RUN;
        SQ_MOVE:  state_d = SQ_RUN;
        default:  state_d = SQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_RUN;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      if (valid_i && mv_first_i) src_q <= addr_i;
    end
  end

  assign squash_o    = valid_i && (state_q == SQ_DROP || state_q == SQ_DROP2);
  assign mv_second_o = valid_i && (state_q == SQ_MOVE);
  assign src_o       = src_q;

  // R10
  drop2_after_mv1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_DROP && valid_i && word_mv1_i) |=> (state_q == SQ_DROP2));
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
  import bexu_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  wreg_i,
  input  logic [DATA_W-1:0]  fopd_i,
  input  logic [FLG_W-1:0]   flags_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               wr_w_o,
  output logic               wr_f_o,
  output logic [FLG_W-1:0]   flags_o,
  output logic               skip_o,
  output logic               squash_o,
  output logic [1:0]         cycles_o,
  output logic               move_o,
  output logic [ADDR_W-1:0]  mv_src_o,
  output logic [ADDR_W-1:0]  mv_dst_o
);
  localparam int unsigned D_BIT = INSTR_W - 7;

  op_e               op;
  tgt_e              tgt;
  logic [DATA_W-1:0] alu_res;
  logic [FLG_W-1:0]  alu_flags;
  logic              alu_cond;
  logic              mv_second;
  logic              exec;
  logic              mv_first;

  bexu_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr_i (instr_i),
    .op_o    (op),
    .tgt_o   (tgt)
  );

  bexu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (op),
    .w_i     (wreg_i),
    .f_i     (fopd_i),
    .flags_i (flags_i),
    .res_o   (alu_res),
    .flags_o (alu_flags),
    .cond_o  (alu_cond)
  );

  bexu_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .skip_take_i (skip_o),
    .mv_first_i  (mv_first),
    .word_mv1_i  (op == OP_MV1),
    .addr_i      (instr_i[ADDR_W-1:0]),
    .squash_o    (squash_o),
    .mv_second_o (mv_second),
    .src_o       (mv_src_o)
  );

  // word executes as itself only outside a squash or move tail
  assign exec     = valid_i && !squash_o && !mv_second;
  assign mv_first = exec && (op == OP_MV1);
  assign result_o = alu_res;
  assign wr_w_o   = exec && (tgt == TGT_W);
  assign wr_f_o   = exec && (tgt == TGT_F);
  assign flags_o  = exec ? alu_flags : flags_i;
  assign skip_o   = exec && is_skip_op(op) && alu_cond;
  assign move_o   = mv_second;
  assign mv_dst_o = instr_i[ADDR_W-1:0];

  always_comb begin
    cycles_o = 2'd0;
    if (valid_i) cycles_o = (skip_o || mv_first) ? 2'd2 : 2'd1;
  end

  // R1
  wb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_w_o, wr_f_o, move_o}));
  // R1
  w_dest_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_w_o |-> !instr_i[D_BIT]);
  // R9
  skip_then_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> (!valid_i || squash_o));
  // R9
  squash_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (!wr_w_o && !wr_f_o && !skip_o && !move_o && flags_o == flags_i));
  // R11
  move_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    move_o |-> (flags_o == flags_i && !wr_w_o && !wr_f_o));
  // R12
  nop_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[INSTR_W-1 -: 4] == 4'hF) |-> (!wr_w_o && !wr_f_o && !skip_o && flags_o == flags_i));
  // R13
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!wr_w_o && !wr_f_o && !skip_o && !move_o && cycles_o == 2'd0));
endmodule

// File: tb/byte_exec_unit_tb.sv
module byte_exec_unit_tb_top;
  localparam int NV = 30;
  // {instr, w, f, flags_in, result, wr_w, wr_f, flags_out, skip}
  localparam logic [52:0] VECS [NV] = '{
    {16'h2620, 8'h7F, 8'h01, 5'h00, 8'h80, 1'b0, 1'b1, 5'h1A, 1'b0}, // R2 add
    {16'h2020, 8'hFF, 8'h00, 5'h01, 8'h00, 1'b1, 1'b0, 5'h07, 1'b0}, // R2 addc
    {16'h5E20, 8'h07, 8'h05, 5'h0F, 8'hFE, 1'b0, 1'b1, 5'h10, 1'b0}, // R2 subwf
    {16'h5820, 8'h01, 8'h10, 5'h00, 8'h0E, 1'b1, 1'b0, 5'h01, 1'b0}, // R2 subwfb
    {16'h5620, 8'h80, 8'h01, 5'h01, 8'h7F, 1'b0, 1'b1, 5'h09, 1'b0}, // R2 subfwb
    {16'h2820, 8'h00, 8'hFF, 5'h00, 8'h00, 1'b1, 1'b0, 5'h07, 1'b0}, // R2 inc
    {16'h0620, 8'h00, 8'h80, 5'h00, 8'h7F, 1'b0, 1'b1, 5'h09, 1'b0}, // R2 dec
    {16'h6C20, 8'h00, 8'h01, 5'h0F, 8'hFF, 1'b0, 1'b1, 5'h10, 1'b0}, // R2 neg
    {16'h1420, 8'hF0, 8'h0F, 5'h1B, 8'h00, 1'b1, 1'b0, 5'h0F, 1'b0}, // R3 and
    {16'h1A20, 8'h55, 8'hFF, 5'h00, 8'hAA, 1'b0, 1'b1, 5'h10, 1'b0}, // R3 xor
    {16'h1C20, 8'h00, 8'h0F, 5'h04, 8'hF0, 1'b1, 1'b0, 5'h10, 1'b0}, // R3 com
    {16'h1020, 8'h00, 8'h00, 5'h00, 8'h00, 1'b1, 1'b0, 5'h04, 1'b0}, // R3 ior
    {16'h5220, 8'h00, 8'h80, 5'h01, 8'h80, 1'b0, 1'b1, 5'h11, 1'b0}, // R3 movf
    {16'h6A20, 8'h00, 8'h55, 5'h1B, 8'h00, 1'b0, 1'b1, 5'h1F, 1'b0}, // R5 clr
    {16'h6820, 8'h00, 8'h12, 5'h00, 8'hFF, 1'b0, 1'b1, 5'h00, 1'b0}, // R5 set
    {16'h6E20, 8'h3C, 8'h00, 5'h05, 8'h3C, 1'b0, 1'b1, 5'h05, 1'b0}, // R5 movwf
    {16'h3620, 8'h00, 8'h81, 5'h02, 8'h02, 1'b0, 1'b1, 5'h03, 1'b0}, // R4 rlc
    {16'h4420, 8'h00, 8'h81, 5'h11, 8'h03, 1'b1, 1'b0, 5'h01, 1'b0}, // R4 rln
    {16'h3020, 8'h00, 8'h01, 5'h00, 8'h00, 1'b1, 1'b0, 5'h05, 1'b0}, // R4 rrc
    {16'h4220, 8'h00, 8'h01, 5'h00, 8'h80, 1'b0, 1'b1, 5'h10, 1'b0}, // R4 rrn
    {16'h3820, 8'h00, 8'hA5, 5'h1F, 8'h5A, 1'b1, 1'b0, 5'h1F, 1'b0}, // R5 swap
    {16'h6220, 8'h10, 8'h20, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b0}, // R6 cpeq
    {16'h6420, 8'h7F, 8'h80, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b1}, // R6 cpgt
    {16'h6020, 8'hFF, 8'h01, 5'h0A, 8'h00, 1'b0, 1'b0, 5'h0A, 1'b1}, // R6 cplt
    {16'h6620, 8'h00, 8'h00, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b1}, // R6 tst
    {16'h3E20, 8'h00, 8'hFF, 5'h00, 8'h00, 1'b0, 1'b1, 5'h00, 1'b1}, // R7 incsz
    {16'h4820, 8'h00, 8'hFF, 5'h10, 8'h00, 1'b1, 1'b0, 5'h10, 1'b0}, // R7 incsnz
    {16'h2C20, 8'h00, 8'h01, 5'h00, 8'h00, 1'b1, 1'b0, 5'h00, 1'b1}, // R7 decsz
    {16'h4E20, 8'h00, 8'h01, 5'h00, 8'h00, 1'b0, 1'b1, 5'h00, 1'b0}, // R7 decsnz
    {16'hF123, 8'h00, 8'h00, 5'h0A, 8'h00, 1'b0, 1'b0, 5'h0A, 1'b0}  // R12 nop
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [7:0]  wreg_i = '0, fopd_i = '0;
  logic [4:0]  flags_i = '0;
  logic [7:0]  result_o;
  logic        wr_w_o, wr_f_o, skip_o, squash_o, move_o;
  logic [4:0]  flags_o;
  logic [1:0]  cycles_o;
  logic [11:0] mv_src_o, mv_dst_o;
  int checks = 0, errors = 0;

  always #4 clk_i = ~clk_i;

  byte_exec_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .instr_i, .wreg_i, .fopd_i, .flags_i,
    .result_o, .wr_w_o, .wr_f_o, .flags_o, .skip_o, .squash_o, .cycles_o,
    .move_o, .mv_src_o, .mv_dst_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] ins, input logic [7:0] w, input logic [7:0] f, input logic [4:0] fl);
    @(negedge clk_i);
    valid_i = v; instr_i = ins; wreg_i = w; fopd_i = f; flags_i = fl;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #2;
    // R14 reset state
    chk("R14", "strobes", {wr_w_o, wr_f_o, skip_o, squash_o, move_o}, 0);
    chk("R14", "cycles", cycles_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VECS[i];
      drive(1'b1, v[52:37], v[36:29], v[28:21], v[20:16]);
      chk("R1", $sformatf("wr_w v%0d", i), wr_w_o, v[7]);
      chk("R1", $sformatf("wr_f v%0d", i), wr_f_o, v[6]);
      chk("R2-5", $sformatf("flags v%0d", i), flags_o, v[5:1]);
      chk("R6", $sformatf("skip v%0d", i), skip_o, v[0]);
      chk("R8", $sformatf("cycles v%0d", i), cycles_o, v[0] ? 2 : 1);
      if (v[7] || v[6]) chk("R2", $sformatf("result v%0d", i), result_o, v[15:8]);
      if (v[0]) begin
        drive(1'b1, 16'h2620, 8'h01, 8'h01, 5'h00);
        chk("R9", $sformatf("squash after v%0d", i), {squash_o, wr_f_o}, 2'b10);
      end
    end

    // R9 taken skip, idle gap, then squashed add with flags passing through
    drive(1'b1, 16'h6220, 8'h33, 8'h33, 5'h00);
    chk("R6", "cpeq equal skip", skip_o, 1);
    drive(1'b0, 16'h0000, 8'h00, 8'h00, 5'h00);
    chk("R13", "idle strobes", {wr_w_o, wr_f_o, skip_o, squash_o, move_o, cycles_o}, 0);
    drive(1'b1, 16'h2620, 8'h7F, 8'h01, 5'h03);
    chk("R9", "squashed add", {squash_o, wr_w_o, wr_f_o, skip_o}, 4'b1000);
    chk("R9", "squashed flags", flags_o, 5'h03);
    drive(1'b1, 16'h2620, 8'h7F, 8'h01, 5'h00);
    chk("R9", "resume after squash", {squash_o, wr_f_o, flags_o}, {2'b01, 5'h1A});

    // R10 skip over two-word move
    drive(1'b1, 16'h6620, 8'h00, 8'h00, 5'h00);
    chk("R6", "tst skip", skip_o, 1);
    drive(1'b1, 16'hC123, 8'h00, 8'h00, 5'h00);
    chk("R10", "first move word squashed", {squash_o, cycles_o}, {1'b1, 2'd1});
    drive(1'b1, 16'hF456, 8'h00, 8'h00, 5'h00);
    chk("R10", "second move word squashed", {squash_o, move_o}, 2'b10);
    drive(1'b1, 16'h1020, 8'h00, 8'h00, 5'h00);
    chk("R10", "resume after 3-cycle skip", {squash_o, wr_w_o, flags_o}, {2'b01, 5'h04});

    // R11 two-word move with idle gap
    drive(1'b1, 16'hC0AB, 8'h00, 8'h00, 5'h15);
    chk("R11", "first word", {wr_w_o, wr_f_o, move_o, cycles_o}, {3'b000, 2'd2});
    drive(1'b0, 16'h0000, 8'h00, 8'h00, 5'h15);
    chk("R13", "move waits", move_o, 0);
    drive(1'b1, 16'hF0CD, 8'h00, 8'h00, 5'h15);
    chk("R11", "move strobe", move_o, 1);
    chk("R11", "src", mv_src_o, 12'h0AB);
    chk("R11", "dst", mv_dst_o, 12'h0CD);
    chk("R11", "flags kept", flags_o, 5'h15);
    drive(1'b1, 16'hF0CD, 8'h00, 8'h00, 5'h00);
    chk("R12", "lone 1111 is nop", {move_o, wr_w_o, wr_f_o, skip_o}, 0);

    // R7 untaken skip does not squash the next word
    drive(1'b1, 16'h2C20, 8'h00, 8'h05, 5'h00);
    chk("R7", "decsz not taken", {skip_o, wr_w_o, result_o}, {2'b01, 8'h04});
    drive(1'b1, 16'h2820, 8'h00, 8'h01, 5'h00);
    chk("R9", "no squash after untaken", {squash_o, wr_w_o, result_o}, {2'b01, 8'h02});

    drive(1'b0, 16'h0000, 8'h00, 8'h00, 5'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule